// File: doc/BRIEF.md
# Majority Coincidence Trigger

This block forms low-momentum trigger candidates from hit bits on several detector layers. The hits are sampled once per bunch-crossing clock, which runs at no more than 40 MHz. Each layer is a group of `CH` channels, 20 by default. Wire planes and strip planes arrive on separate buses, and each has four layers. An inner-station bus carries one more group of `CH` bits.

Every layer passes through its own delay line, which can hold it back by 0 to 7 clocks so that layers with different arrival times line up. A single mode input selects both the coincidence scheme and the trigger type:

- wire 3-of-4
- wire 2-of-3
- strip 3-of-4
- strip 2-of-3
- a 1-of-2 wire condition gated by the inner station

On each channel, a layer counts as hit when that channel or a direct neighbour is set. The registered outputs are one coincidence flag per channel and a type code that identifies the active trigger type.

Top module: `majority_trigger`

## Requirements
- R1: After reset, `coin` is all zero and `type_code` is 0 until the first clock edge that follows reset release.
- R2: In mode 0 (wire) and mode 2 (strip), `coin[i]` is 1 when at least 3 of the four layers of the selected plane count as hit at channel i.
- R3: In mode 1 (wire) and mode 3 (strip), `coin[i]` is 1 when at least 2 of layers 0 to 2 count as hit at channel i. Layer 3 has no effect in these modes.
- R4: In modes 0 and 1 the strip bus has no effect on the outputs. In modes 2 and 3 the wire bus has no effect on the outputs.
- R5: In mode 4, `coin[i]` is 1 when wire layer 0 or wire layer 1 counts as hit at channel i and at least one bit of the delayed inner bus is set. If no delayed inner bit is set, `coin` is all zero.
- R6: A layer counts as hit at channel i when its delayed bit i, i-1 or i+1 is set. Positions outside 0 to CH-1 do not exist, so there is no wrap-around between channel 0 and channel CH-1.
- R7: Layer l of a plane is bits `[l*CH +: CH]` of `wire_hit` or `strip_hit`. Its delay is field `[l*DLY_W +: DLY_W]` of `wire_dly` or `strip_dly`, and `inner_dly` delays `inner_hit`. A layer with delay d applied alone affects `coin` exactly d+1 rising edges after its bits are presented, and for exactly one cycle when the bits are a one-cycle pulse.
- R8: Layers with different delays combine as they stand after their own delays. Pulses whose timing is offset by the difference in delays produce a coincidence. The same pulses sent at the same time do not.
- R9: `type_code` equals the mode value plus 1 (1 to 5) one edge after a legal mode (0 to 4) is presented. A nonzero `coin` is always accompanied by a nonzero `type_code`.
- R10: Mode values 5 to 7 force `coin` to zero and `type_code` to 0 from the next edge, whatever the hit inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Scheme and trigger-type select (0 to 4 legal) |
| wire_dly | input | 4*DLY_W | Per-layer delay settings, wire plane |
| strip_dly | input | 4*DLY_W | Per-layer delay settings, strip plane |
| inner_dly | input | DLY_W | Delay setting for the inner-station bus |
| wire_hit | input | 4*CH | Wire layer hits, layer l in bits [l*CH +: CH] |
| strip_hit | input | 4*CH | Strip layer hits, layer l in bits [l*CH +: CH] |
| inner_hit | input | CH | Inner-station hits |
| coin | output | CH | Registered per-channel coincidence flags |
| type_code | output | 3 | Registered trigger type: 0 none, 1 to 5 for modes 0 to 4 |

## Verification
A change on the hit inputs of a layer reaches `coin` d+1 rising edges later, where d is that layer's delay. A change of `mode` reaches `type_code` one edge later.

The bench drives every input on the falling edge and samples on falling edges. It counts edges from each stimulus, so the latency sweeps check every cycle of a window and expect the pulse only at edge d+1. For the wide pattern sweeps it holds inputs and delays for nine edges, which exceeds the longest path of eight. It then compares against an arithmetic model of the layer counts.

// File: rtl/mjt_pkg.sv
package mjt_pkg;
    localparam int NUM_LAYERS = 4;
    localparam int MODE_W     = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_WIRE_3OF4  = 3'd0,
        MODE_WIRE_2OF3  = 3'd1,
        MODE_STRIP_3OF4 = 3'd2,
        MODE_STRIP_2OF3 = 3'd3,
        MODE_INNER_1OF2 = 3'd4
    } trig_mode_e;

    localparam logic [MODE_W-1:0] MODE_LAST = 3'd4;
endpackage

// File: rtl/mjt_delay_line.sv
module mjt_delay_line #(
    parameter int W     = 20,
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    localparam int NTAP  = 1 << DLY_W;
    localparam int DEPTH = NTAP - 1;

    logic [W-1:0] sr_q [DEPTH];
    logic [W-1:0] sr_d [DEPTH];
    logic [W-1:0] taps [NTAP];

    always_comb begin
        sr_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sr_q[i] <= '0;
            end
        end else begin
            sr_q <= sr_d;
        end
    end

    always_comb begin
        taps[0] = din;
        for (int i = 1; i < NTAP; i++) begin
            taps[i] = sr_q[i-1];
        end
    end

    assign dout = taps[dly];

    // checker state: set once a real input sample has been captured
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_delay_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && dly == DLY_W'(1) && $past(dly) == DLY_W'(1)) |-> (dout == $past(din)));
endmodule

// File: rtl/mjt_kofn.sv
module mjt_kofn #(
    parameter int W = 20,
    parameter int N = 4,
    parameter int K = 3
) (
    input  logic [N*W-1:0] lay_flat,
    output logic [W-1:0]   hit
);
    localparam int CW = $clog2(N + 1);

    logic [W-1:0] spread [N];

    for (genvar l = 0; l < N; l++) begin : g_spread
        logic [W-1:0] lay;
        assign lay       = lay_flat[l*W +: W];
        assign spread[l] = lay | (lay << 1) | (lay >> 1);
    end

    always_comb begin
        logic [CW-1:0] cnt;
        for (int i = 0; i < W; i++) begin
            cnt = '0;
            for (int l = 0; l < N; l++) begin
                cnt = cnt + CW'(spread[l][i]);
            end
            hit[i] = (cnt >= CW'(K));
        end
    end
endmodule

// File: rtl/majority_trigger.sv
module majority_trigger
    import mjt_pkg::*;
#(
    parameter int CH    = 20,
    parameter int DLY_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [MODE_W-1:0]          mode,
    input  logic [NUM_LAYERS*DLY_W-1:0] wire_dly,
    input  logic [NUM_LAYERS*DLY_W-1:0] strip_dly,
    input  logic [DLY_W-1:0]           inner_dly,
    input  logic [NUM_LAYERS*CH-1:0]   wire_hit,
    input  logic [NUM_LAYERS*CH-1:0]   strip_hit,
    input  logic [CH-1:0]              inner_hit,
    output logic [CH-1:0]              coin,
    output logic [MODE_W-1:0]          type_code
);
    typedef struct packed {
        logic [CH-1:0]     coin;
        logic [MODE_W-1:0] kind;
    } out_t;

    logic [NUM_LAYERS*CH-1:0] wire_al;
    logic [NUM_LAYERS*CH-1:0] strip_al;
    logic [CH-1:0]            inner_al;

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        mjt_delay_line #(.W(CH), .DLY_W(DLY_W)) u_wire_dl (
            .clk  (clk),
            .rst_n(rst_n),
            .dly  (wire_dly[l*DLY_W +: DLY_W]),
            .din  (wire_hit[l*CH +: CH]),
            .dout (wire_al[l*CH +: CH])
        );
        mjt_delay_line #(.W(CH), .DLY_W(DLY_W)) u_strip_dl (
            .clk  (clk),
            .rst_n(rst_n),
            .dly  (strip_dly[l*DLY_W +: DLY_W]),
            .din  (strip_hit[l*CH +: CH]),
            .dout (strip_al[l*CH +: CH])
        );
    end

    mjt_delay_line #(.W(CH), .DLY_W(DLY_W)) u_inner_dl (
        .clk  (clk),
        .rst_n(rst_n),
        .dly  (inner_dly),
        .din  (inner_hit),
        .dout (inner_al)
    );

    logic [CH-1:0] w34_hit, w23_hit, s34_hit, s23_hit, w12_hit;
    logic          inner_any;

    mjt_kofn #(.W(CH), .N(4), .K(3)) u_w34 (.lay_flat(wire_al),                .hit(w34_hit));
    mjt_kofn #(.W(CH), .N(3), .K(2)) u_w23 (.lay_flat(wire_al[3*CH-1:0]),     .hit(w23_hit));
    mjt_kofn #(.W(CH), .N(4), .K(3)) u_s34 (.lay_flat(strip_al),               .hit(s34_hit));
    mjt_kofn #(.W(CH), .N(3), .K(2)) u_s23 (.lay_flat(strip_al[3*CH-1:0]),    .hit(s23_hit));
    mjt_kofn #(.W(CH), .N(2), .K(1)) u_w12 (.lay_flat(wire_al[2*CH-1:0]),     .hit(w12_hit));

    assign inner_any = |inner_al;

    out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        case (mode)
            MODE_WIRE_3OF4:  begin out_d.coin = w34_hit; out_d.kind = 3'd1; end
            MODE_WIRE_2OF3:  begin out_d.coin = w23_hit; out_d.kind = 3'd2; end
            MODE_STRIP_3OF4: begin out_d.coin = s34_hit; out_d.kind = 3'd3; end
            MODE_STRIP_2OF3: begin out_d.coin = s23_hit; out_d.kind = 3'd4; end
            MODE_INNER_1OF2: begin
                out_d.coin = w12_hit & {CH{inner_any}};
                out_d.kind = 3'd5;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign coin      = out_q.coin;
    assign type_code = out_q.kind;

    assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > MODE_LAST) |=> (coin == '0 && type_code == '0));

    assert_type_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode <= MODE_LAST) |=> (type_code == $past(mode) + 3'd1));

    assert_coin_typed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|coin) |-> (type_code != '0));

    assert_inner_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INNER_1OF2 && !inner_any) |=> (coin == '0));
endmodule

// File: tb/majority_trigger_tb.sv
module majority_trigger_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CH    = 6;
    localparam int DLY_W = 3;
    localparam int NL    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode = '0;
    logic [NL*DLY_W-1:0] wire_dly = '0;
    logic [NL*DLY_W-1:0] strip_dly = '0;
    logic [DLY_W-1:0]  inner_dly = '0;
    logic [NL*CH-1:0]  wire_hit = '0;
    logic [NL*CH-1:0]  strip_hit = '0;
    logic [CH-1:0]     inner_hit = '0;
    logic [CH-1:0]     coin;
    logic [2:0]        type_code;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    majority_trigger #(.CH(CH), .DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .wire_dly(wire_dly), .strip_dly(strip_dly), .inner_dly(inner_dly),
        .wire_hit(wire_hit), .strip_hit(strip_hit), .inner_hit(inner_hit),
        .coin(coin), .type_code(type_code)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [CH-1:0] model_coin(input logic [2:0] m,
            input logic [NL*CH-1:0] w, input logic [NL*CH-1:0] s,
            input logic [CH-1:0] inn);
        logic [NL*CH-1:0] src;
        int nl, need;
        logic gate;
        logic [CH-1:0] r;
        r = '0;
        case (m)
            3'd0: begin src = w; nl = 4; need = 3; end
            3'd1: begin src = w; nl = 3; need = 2; end
            3'd2: begin src = s; nl = 4; need = 3; end
            3'd3: begin src = s; nl = 3; need = 2; end
            3'd4: begin src = w; nl = 2; need = 1; end
            default: return '0;
        endcase
        gate = (m == 3'd4) ? (inn != '0) : 1'b1;
        for (int i = 0; i < CH; i++) begin
            int c;
            c = 0;
            for (int l = 0; l < nl; l++) begin
                bit h;
                h = 1'b0;
                for (int j = i - 1; j <= i + 1; j++) begin
                    if (j >= 0 && j < CH && src[l*CH + j]) h = 1'b1;
                end
                if (h) c++;
            end
            r[i] = gate && (c >= need);
        end
        return r;
    endfunction

    function automatic logic [2:0] model_type(input logic [2:0] m);
        return (m <= 3'd4) ? m + 3'd1 : 3'd0;
    endfunction

    task automatic check(input string req, input logic [CH-1:0] ec, input logic [2:0] et);
        vectors++;
        if (coin !== ec || type_code !== et) begin
            errors++;
            $display("FAIL %s: coin=%b type=%0d expected coin=%b type=%0d",
                     req, coin, type_code, ec, et);
        end
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_hits();
        wire_hit = '0; strip_hit = '0; inner_hit = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_edges(3);
        check("R1", '0, 3'd0);
        rst_n = 1'b1;
        check("R1", '0, 3'd0);

        // Sweep over every mode with pseudo-random patterns and delays (R2 R3 R4 R5 R6 R9 R10)
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 48; p++) begin
                logic [31:0] a, b, c;
                rng = next_rand(rng); a = rng;
                rng = next_rand(rng); b = rng;
                rng = next_rand(rng); c = rng;
                mode = 3'(m);
                case (p % 3)
                    0: begin wire_hit = a[23:0];         strip_hit = b[23:0]; end
                    1: begin wire_hit = a[23:0] & b[23:0]; strip_hit = b[31:8] & c[23:0]; end
                    default: begin
                        wire_hit  = a[23:0] & b[23:0] & c[23:0];
                        strip_hit = a[31:8] & b[31:8] & c[31:8];
                    end
                endcase
                inner_hit = (p % 4 == 0) ? '0 : CH'(c[31:26]);
                wire_dly  = b[11:0];
                strip_dly = c[11:0];
                inner_dly = a[26:24];
                wait_edges(9);
                check(m > 4 ? "R10" : "R2/R3/R4/R5/R6/R9",
                      model_coin(mode, wire_hit, strip_hit, inner_hit), model_type(mode));
            end
        end

        // R6: adjacency without wrap-around
        wire_dly = '0; strip_dly = '0; inner_dly = '0;
        mode = 3'd0; clear_hits();
        wire_hit[0*CH + 1] = 1'b1; wire_hit[1*CH + 2] = 1'b1; wire_hit[2*CH + 3] = 1'b1;
        wait_edges(2);
        check("R6", 6'b000100, 3'd1);
        clear_hits();
        wire_hit[0*CH + 0] = 1'b1; wire_hit[1*CH + 0] = 1'b1; wire_hit[2*CH + 5] = 1'b1;
        wait_edges(2);
        check("R6", 6'b000000, 3'd1);

        // R3: layer 3 ignored in 2-of-3
        mode = 3'd1; clear_hits();
        wire_hit[0*CH + 4] = 1'b1; wire_hit[3*CH + 4] = 1'b1;
        wait_edges(2);
        check("R3", 6'b000000, 3'd2);

        // R4: strip ignored in wire mode, wire ignored in strip mode
        mode = 3'd0; clear_hits(); strip_hit = '1;
        wait_edges(2);
        check("R4", 6'b000000, 3'd1);
        mode = 3'd2; clear_hits(); wire_hit = '1;
        wait_edges(2);
        check("R4", 6'b000000, 3'd3);

        // R5: inner gate
        mode = 3'd4; clear_hits(); wire_hit[0*CH + 1] = 1'b1;
        wait_edges(2);
        check("R5", 6'b000000, 3'd5);
        inner_hit[5] = 1'b1;
        wait_edges(2);
        check("R5", 6'b000111, 3'd5);

        // R10: illegal mode with all hits
        mode = 3'd6; wire_hit = '1; strip_hit = '1; inner_hit = '1;
        wait_edges(1);
        check("R10", '0, 3'd0);

        // R7: latency of d+1 edges for every delay value
        mode = 3'd0;
        for (int d = 0; d < 8; d++) begin
            clear_hits();
            for (int l = 0; l < NL; l++) wire_dly[l*DLY_W +: DLY_W] = DLY_W'(d);
            wait_edges(10);
            for (int l = 0; l < NL; l++) wire_hit[l*CH + 3] = 1'b1;
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                check("R7", (k == d + 1) ? 6'b011100 : 6'b000000, 3'd1);
                if (k == 1) clear_hits();
            end
        end

        // R8: staggered delays, aligned pulses
        clear_hits();
        for (int l = 0; l < NL; l++) wire_dly[l*DLY_W +: DLY_W] = DLY_W'(3 - l);
        wait_edges(10);
        for (int k = 0; k <= 8; k++) begin
            if (k > 0) check("R8", (k == 4) ? 6'b000111 : 6'b000000, 3'd1);
            clear_hits();
            if (k < NL) wire_hit[k*CH + 1] = 1'b1;
            @(negedge clk);
        end
        // R8: same pulses sent together never align
        clear_hits();
        wait_edges(10);
        for (int l = 0; l < NL; l++) wire_hit[l*CH + 1] = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) clear_hits();
            check("R8", 6'b000000, 3'd1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule